// File: doc/BRIEF.md
# FP8 Mixed-Format Dot-Product Accumulator

This unit takes groups of four 8-bit floating-point values from two operands. It multiplies the values pairwise, lane by lane. It adds the sum of the four products to a running single-precision (FP32) accumulator. A job opens with a one-cycle `start`, which loads the starting accumulator and the number of beats. The job then takes 1 to 16 beats, each marked by `beat_valid`. After the final beat, `done` pulses for one cycle and `acc_out` carries the result.

Each operand has its own format select, so any pairing of the two encodings can be used. The first encoding favours range: 5 exponent bits and 2 mantissa bits. The second favours precision: 4 exponent bits and 3 mantissa bits. Products are formed exactly. On each beat the four products and the current accumulator are summed exactly and then rounded to FP32 once, so no 8-bit intermediate precision ever appears.

Top module: `fp8_dot_acc`

## Requirements
- R1: With format select 0 a byte decodes as sign bit 7, exponent bits 6:2 with bias 15, and mantissa bits 1:0. Exponent 0 gives subnormals. Exponent 31 with mantissa 0 is a signed infinity, and exponent 31 with a nonzero mantissa is NaN (0x3C is 1.0, 0x40 is 2.0).
- R2: With format select 1 a byte decodes as sign bit 7, exponent bits 6:3 with bias 7, and mantissa bits 2:0, with subnormals. There is no infinity: 0x78 is 256 and 0x7E is 448, the largest finite value. Only a byte whose bits 6:0 are all ones is NaN (0x38 is 1.0, 0x30 is 0.5, 0x3C is 1.5).
- R3: `fmt_a` and `fmt_b` select the formats independently, so all four pairings work. Lane k occupies bits 8k+7:8k of `a` and of `b`, and only A lane k is multiplied by B lane k.
- R4: Each beat replaces the accumulator with the exact value of accumulator plus the sum of the four products, rounded once to FP32 with round-to-nearest, ties to even.
- R5: `start` loads `acc_in` and a beat count of `beats_m1`+1, from 1 to 16. On load, a subnormal `acc_in` becomes a zero of the same sign and any NaN becomes 0x7FC00000. While a job runs, only cycles with `beat_valid` high count as beats.
- R6: `done` is high for exactly one cycle, the cycle after the final beat is taken. `acc_out` holds the result from then until the next `start`. After reset `done` is 0 and `acc_out` is 0.
- R7: A NaN in either operand or in the accumulator, an infinity multiplied by zero, or infinities of both signs in one beat produce 0x7FC00000.
- R8: An infinite product, or an infinite accumulator, with no NaN condition present gives an infinity of that sign (0x7F800000 or 0xFF800000).
- R9: When all four products of a beat are zero, the accumulator is kept unchanged, including a negative zero. Otherwise an exact zero sum gives +0 (0x00000000).
- R10: A `beat_valid` received while no job is running is ignored: `acc_out` does not change and `done` stays low.
- R11: A `start` during a running job abandons that job and begins the new one with the new accumulator and beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; loads `acc_in` and `beats_m1` |
| acc_in | input | 32 | Starting FP32 accumulator |
| beats_m1 | input | 4 | Number of beats in the job minus one |
| beat_valid | input | 1 | Current `a`, `b`, `fmt_a`, `fmt_b` form one beat |
| a | input | 32 | Four FP8 elements of operand A |
| b | input | 32 | Four FP8 elements of operand B |
| fmt_a | input | 1 | Format of A: 0 = 5-bit exponent, 1 = 4-bit exponent |
| fmt_b | input | 1 | Format of B: 0 = 5-bit exponent, 1 = 4-bit exponent |
| done | output | 1 | One-cycle strobe when the result is ready |
| acc_out | output | 32 | FP32 accumulator result |

## Verification
The hardest case to reach is a rounding decision that depends on the whole beat being summed before rounding. Rounding after each product would give a different answer in these cases. The stimulus sets the accumulator to 2^24, where one unit in the last place is 2. It then adds four products of 0.5, which must give 2^24+2. It also adds products of 1 and 3, which must land on exact ties that resolve to even. Random multi-beat jobs keep every operand on a grid of 2^-9, so a real-valued reference stays exact and rounds once per beat like the design.

// File: rtl/fp8_dot_acc.sv
module fp8_dot_acc #(
  parameter int LANES     = 4,
  parameter int MAX_BEATS = 16,
  localparam int CW = $clog2(MAX_BEATS),
  localparam int DW = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   acc_in,
  input  logic [CW-1:0] beats_m1,
  input  logic          beat_valid,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          fmt_a,
  input  logic          fmt_b,
  output logic          done,
  output logic [31:0]   acc_out
);

  // bit i of the fixed frame weighs 2^(i-LSB_EXP)
  localparam int LSB_EXP = 149;
  localparam int FW      = LSB_EXP + 128 + 4;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  typedef struct packed {
    logic              nan;
    logic              inf;
    logic              sgn;
    logic [3:0]        sig;
    logic signed [6:0] q;
  } f8_t;

  function automatic f8_t dec8(input logic [7:0] x, input logic e4);
    f8_t r;
    r.sgn = x[7];
    if (!e4) begin
      r.nan = (&x[6:2]) & (|x[1:0]);
      r.inf = (&x[6:2]) & ~(|x[1:0]);
      r.sig = {1'b0, |x[6:2], x[1:0]};
      r.q   = $signed({2'b00, (x[6:2] == 5'd0) ? 5'd1 : x[6:2]}) - 7'sd17;
    end else begin
      r.nan = &x[6:0];
      r.inf = 1'b0;
      r.sig = {|x[6:3], x[2:0]};
      r.q   = $signed({3'b000, (x[6:3] == 4'd0) ? 4'd1 : x[6:3]}) - 7'sd10;
    end
    return r;
  endfunction

  function automatic logic [31:0] load_acc(input logic [31:0] x);
    if (x[30:23] == 8'h00) return {x[31], 31'd0};
    if (x[30:23] == 8'hFF && x[22:0] != 23'd0) return QNAN;
    return x;
  endfunction

  logic [31:0]   acc_r;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          done_r;

  logic [LANES-1:0]      p_nan, p_inf, p_zero, p_neg;
  logic signed [FW-1:0]  p_term [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    f8_t              da, db;
    logic [7:0]       pm;
    logic signed [7:0] qs;
    logic [7:0]       pos;
    logic [FW-1:0]    sh;
    assign da  = dec8(a[8*k +: 8], fmt_a);
    assign db  = dec8(b[8*k +: 8], fmt_b);
    assign pm  = da.sig * db.sig;
    assign qs  = {da.q[6], da.q} + {db.q[6], db.q};
    assign pos = 8'(qs) + 8'(LSB_EXP);
    assign sh  = FW'(pm) << pos;
    assign p_nan[k]  = da.nan | db.nan | (da.inf & (db.sig == 4'd0)) | (db.inf & (da.sig == 4'd0));
    assign p_inf[k]  = da.inf | db.inf;
    assign p_neg[k]  = da.sgn ^ db.sgn;
    assign p_zero[k] = (pm == 8'd0);
    assign p_term[k] = p_neg[k] ? -$signed(sh) : $signed(sh);
  end

  wire [7:0] ae      = acc_r[30:23];
  wire       acc_nan = (ae == 8'hFF) && (acc_r[22:0] != 23'd0);
  wire       acc_inf = (ae == 8'hFF) && (acc_r[22:0] == 23'd0);
  wire [FW-1:0] acc_sh = FW'({ae != 8'h00, acc_r[22:0]}) << (ae - 8'd1);
  wire signed [FW-1:0] acc_term = acc_r[31] ? -$signed(acc_sh) : $signed(acc_sh);

  logic signed [FW-1:0] sum;
  always_comb begin
    sum = acc_term;
    for (int k = 0; k < LANES; k++) sum = sum + p_term[k];
  end

  logic [FW-1:0] mag;
  assign mag = sum[FW-1] ? -sum : sum;

  logic [8:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < FW; i++) if (mag[i]) lead = 9'(i);
  end

  logic [FW-1:0] norm;
  logic [22:0]   mant;
  logic          rnd;
  logic [7:0]    eb;
  logic [30:0]   rounded;
  assign norm    = mag << (9'(FW - 1) - lead);
  assign mant    = norm[FW-2 -: 23];
  assign rnd     = norm[FW-25] & ((|norm[FW-26:0]) | norm[FW-24]);
  assign eb      = 8'(lead - 9'd22);
  assign rounded = {eb, mant} + 31'(rnd);

  wire any_nan = acc_nan | (|p_nan);
  wire pos_inf = (acc_inf & ~acc_r[31]) | (|(p_inf & ~p_neg));
  wire neg_inf = (acc_inf &  acc_r[31]) | (|(p_inf &  p_neg));

  logic [31:0] nxt;
  always_comb begin
    if (any_nan || (pos_inf && neg_inf)) nxt = QNAN;
    else if (pos_inf)                    nxt = 32'h7F80_0000;
    else if (neg_inf)                    nxt = 32'hFF80_0000;
    else if (&p_zero)                    nxt = acc_r;
    else if (mag == '0)                  nxt = 32'h0000_0000;
    else if (lead < 9'd23)               nxt = {sum[FW-1], 31'd0};
    else if (lead > 9'd276)              nxt = {sum[FW-1], 8'hFF, 23'd0};
    else                                 nxt = {sum[FW-1], rounded};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r  <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done_r <= 1'b0;
    end else if (start) begin
      acc_r  <= load_acc(acc_in);
      cnt    <= beats_m1;
      busy   <= 1'b1;
      done_r <= 1'b0;
    end else if (busy && beat_valid) begin
      acc_r  <= nxt;
      cnt    <= cnt - 1'b1;
      busy   <= (cnt != '0);
      done_r <= (cnt == '0);
    end else begin
      done_r <= 1'b0;
    end
  end

  assign done    = done_r;
  assign acc_out = acc_r;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy && beat_valid && !start));
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_canon_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_r[30:23] == 8'hFF && acc_r[22:0] != 23'd0) |-> acc_r == QNAN);
  assert_no_subnormal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_r[30:23] == 8'h00) |-> acc_r[22:0] == 23'd0);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(acc_r) && !done));

endmodule

// File: tb/fp8_dot_acc_tb.sv
`timescale 1ns/1ps
module fp8_dot_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] acc_in = '0;
  logic [3:0]  beats_m1 = '0;
  logic        beat_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        fmt_a = 1'b0, fmt_b = 1'b0;
  logic        done;
  logic [31:0] acc_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5679;

  fp8_dot_acc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in), .beats_m1(beats_m1),
    .beat_valid(beat_valid), .a(a), .b(b), .fmt_a(fmt_a), .fmt_b(fmt_b),
    .done(done), .acc_out(acc_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic real p2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real f8r(input logic [7:0] x, input logic e4);
    real v;
    int  e, m;
    if (!e4) begin
      e = int'(x[6:2]); m = int'(x[1:0]);
      v = (e == 0) ? m * p2(-16) : (4 + m) * p2(e - 17);
    end else begin
      e = int'(x[6:3]); m = int'(x[2:0]);
      v = (e == 0) ? m * p2(-9) : (8 + m) * p2(e - 10);
    end
    return x[7] ? -v : v;
  endfunction

  function automatic real f32r(input logic [31:0] x);
    real v;
    if (x[30:23] == 8'h00) return 0.0;
    v = (real'(8388608) + real'(x[22:0])) * p2(int'(x[30:23]) - 150);
    return x[31] ? -v : v;
  endfunction

  function automatic logic [31:0] r2f32(input real v);
    logic [63:0] bits;
    logic [24:0] m;
    int          ex;
    if (v == 0.0) return 32'h0;
    bits = $realtobits(v);
    ex = int'(bits[62:52]) - 1023;
    m  = {2'b01, bits[51:29]};
    if (bits[28] && ((|bits[27:0]) || m[0])) m = m + 1'b1;
    if (m[24]) begin m = m >> 1; ex++; end
    if (ex < -126) return {bits[63], 31'd0};
    return {bits[63], 8'(ex + 127), m[22:0]};
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic start_job(input logic [31:0] acc, input int n);
    @(negedge clk);
    start = 1'b1; acc_in = acc; beats_m1 = 4'(n - 1);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic beat(input logic [31:0] va, input logic [31:0] vb, input logic fa, input logic fb);
    a = va; b = vb; fmt_a = fa; fmt_b = fb; beat_valid = 1'b1;
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic one(input string req, input logic [31:0] acc, input logic [31:0] va,
                     input logic [31:0] vb, input logic fa, input logic fb, input logic [31:0] exp);
    start_job(acc, 1);
    beat(va, vb, fa, fb);
    chk({req, " done"}, 32'(done), 32'd1);
    chk(req, acc_out, exp);
  endtask

  task automatic t_reset;
    chk("R6 reset done", 32'(done), 32'd0);
    chk("R6 reset acc_out", acc_out, 32'h0);
  endtask

  task automatic t_basic;
    one("R4 four lanes", 32'h3F80_0000, 32'h3838_3838, 32'h3838_3838, 1'b1, 1'b1, 32'h40A0_0000);
  endtask

  task automatic t_pairings;
    one("R3 R2 e4 x e4", 32'h0, 32'h0000_003C, 32'h0000_003C, 1'b1, 1'b1, 32'h4010_0000);
    one("R3 R1 e5 x e4", 32'h0, 32'h0000_003C, 32'h0000_003C, 1'b0, 1'b1, 32'h3FC0_0000);
    one("R3 e4 x e5",    32'h0, 32'h0000_003C, 32'h0000_003C, 1'b1, 1'b0, 32'h3FC0_0000);
    one("R1 e5 x e5",    32'h0, 32'h0000_003C, 32'h0000_0040, 1'b0, 1'b0, 32'h4000_0000);
  endtask

  task automatic t_lanes;
    one("R3 R9 lane mismatch", 32'h3F80_0000, 32'h0000_3800, 32'h0000_0030, 1'b1, 1'b1, 32'h3F80_0000);
    one("R3 lane1",            32'h3F80_0000, 32'h0000_3800, 32'h0000_3000, 1'b1, 1'b1, 32'h3FC0_0000);
    one("R3 lane3",            32'h0,         32'h3800_0000, 32'h3800_0000, 1'b1, 1'b1, 32'h3F80_0000);
  endtask

  task automatic t_range;
    one("R2 max 448",  32'h0, 32'h0000_007E, 32'h0000_0038, 1'b1, 1'b1, 32'h43E0_0000);
    one("R2 0x78=256", 32'h0, 32'h0000_0078, 32'h0000_0038, 1'b1, 1'b1, 32'h4380_0000);
    one("R1 R2 subnormals", 32'h0, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 32'h3300_0000);
  endtask

  task automatic t_round;
    one("R4 tie to even", 32'h4B80_0000, 32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1, 32'h4B80_0000);
    one("R4 single rounding", 32'h4B80_0000, 32'h3838_3838, 32'h3030_3030, 1'b1, 1'b1, 32'h4B80_0001);
    one("R4 tie up to even", 32'h4B80_0000, 32'h0038_3838, 32'h0038_3838, 1'b1, 1'b1, 32'h4B80_0002);
  endtask

  task automatic t_specials;
    one("R7 e4 nan",       32'h0, 32'h0000_007F, 32'h0000_0038, 1'b1, 1'b1, 32'h7FC0_0000);
    one("R7 R1 e5 nan",    32'h0, 32'h0000_007D, 32'h0000_0038, 1'b0, 1'b1, 32'h7FC0_0000);
    one("R7 inf x zero",   32'h0, 32'h0000_007C, 32'h0000_0000, 1'b0, 1'b1, 32'h7FC0_0000);
    one("R8 R1 +inf",      32'h0, 32'h0000_007C, 32'h0000_0038, 1'b0, 1'b1, 32'h7F80_0000);
    one("R8 -inf",         32'h0, 32'h0000_00FC, 32'h0000_0038, 1'b0, 1'b1, 32'hFF80_0000);
    one("R7 +inf -inf",    32'h0, 32'h0000_FC7C, 32'h0000_3838, 1'b0, 1'b1, 32'h7FC0_0000);
    one("R8 acc inf",      32'h7F80_0000, 32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1, 32'h7F80_0000);
    one("R7 -inf acc +inf prod", 32'hFF80_0000, 32'h0000_007C, 32'h0000_0038, 1'b0, 1'b1, 32'h7FC0_0000);
    one("R5 R7 acc nan canon",   32'h7F80_0001, 32'h0, 32'h0, 1'b1, 1'b1, 32'h7FC0_0000);
  endtask

  task automatic t_zero;
    one("R9 -0 kept",          32'h8000_0000, 32'h0, 32'h0, 1'b1, 1'b1, 32'h8000_0000);
    one("R5 subnormal flush",  32'h0000_0001, 32'h0, 32'h0, 1'b1, 1'b1, 32'h0000_0000);
    one("R5 neg subnormal",    32'h8040_0000, 32'h0, 32'h0, 1'b1, 1'b1, 32'h8000_0000);
    one("R9 cancel to +0",     32'hBF80_0000, 32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1, 32'h0000_0000);
    one("R5 flushed acc plus 1", 32'h0040_0000, 32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1, 32'h3F80_0000);
  endtask

  task automatic t_multi;
    logic early = 1'b0;
    start_job(32'h0, 16);
    for (int i = 0; i < 16; i++) begin
      beat(32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1);
      if (i < 15) begin
        if (done) early = 1'b1;
        repeat (i % 3) @(negedge clk);
        if (done) early = 1'b1;
      end
    end
    chk("R5 no early done", 32'(early), 32'd0);
    chk("R6 done after 16", 32'(done), 32'd1);
    chk("R5 16 beats sum", acc_out, 32'h4180_0000);
    @(negedge clk);
    chk("R6 done one cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk("R6 result held", acc_out, 32'h4180_0000);
  endtask

  task automatic t_idle;
    beat(32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1);
    chk("R10 idle beat no done", 32'(done), 32'd0);
    chk("R10 idle beat no change", acc_out, 32'h4180_0000);
  endtask

  task automatic t_restart;
    logic early = 1'b0;
    start_job(32'h0, 4);
    beat(32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1);
    beat(32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1);
    if (done) early = 1'b1;
    start_job(32'h4120_0000, 1);
    if (done) early = 1'b1;
    beat(32'h0000_0038, 32'h0000_0038, 1'b1, 1'b1);
    chk("R11 no done from abandoned job", 32'(early), 32'd0);
    chk("R11 restart done", 32'(done), 32'd1);
    chk("R11 restart value", acc_out, 32'h4130_0000);
  endtask

  function automatic logic [7:0] gen8(input logic [31:0] r, input logic e4);
    logic [7:0] x;
    if (e4) begin
      x = r[7:0];
      if (x[6:0] == 7'h7F) x = x ^ 8'h01;
    end else begin
      x = {r[7], 5'(5'd8 + {1'b0, r[3:0]}), r[5:4]};
    end
    return x;
  endfunction

  task automatic t_random;
    for (int j = 0; j < 8; j++) begin
      logic [31:0] ref_bits;
      logic [31:0] va, vb;
      logic        fa, fb;
      int          n;
      real         s;
      seed = xs(seed);
      n = 1 + int'(seed[3:0]);
      ref_bits = r2f32(real'($signed(seed[31:16])) * p2(-8));
      start_job(ref_bits, n);
      for (int i = 0; i < n; i++) begin
        seed = xs(seed);
        fa = seed[0]; fb = seed[1];
        s = 0.0;
        for (int k = 0; k < 4; k++) begin
          seed = xs(seed);
          va[8*k +: 8] = gen8(seed, fa);
          seed = xs(seed);
          vb[8*k +: 8] = gen8(seed, fb);
          s = s + f8r(va[8*k +: 8], fa) * f8r(vb[8*k +: 8], fb);
        end
        ref_bits = r2f32(f32r(ref_bits) + s);
        beat(va, vb, fa, fb);
      end
      chk("R4 R3 random job done", 32'(done), 32'd1);
      chk("R4 R3 random job value", acc_out, ref_bits);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pairings();
    t_lanes();
    t_range();
    t_round();
    t_specials();
    t_zero();
    t_multi();
    t_idle();
    t_restart();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule